// File: doc/BRIEF.md
# Sampling-Window Transaction Event Counter

This block is a performance monitor for a bus bridge. Software writes a duration, counted in bus clocks, into the window timer register. That write also opens a measurement window. While the window is open, an event counter adds up the successful I/O reads reported by two secondary ports. Each port gives a single-cycle strobe per completed read. When the timer runs down to zero, the window closes and both the timer and the count return to zero. Software can read the remaining clocks and the live count at any time through a small register port.

Read responses come out as a stream: a read request produces exactly one `rd_valid` pulse carrying `rd_data` on the next clock. There is no back-pressure. The requester must accept every response in the cycle it appears, and read requests may be issued back to back on every clock. Writes and the event strobes are plain control inputs with no handshake.

Address map (word addresses on `wr_addr` and `rd_addr`):
- 0: window timer
- 1: event count
- 2 and 3: unused; they read as zero and ignore writes

Top module: `perf_window_counter`

## Requirements
- R1: After reset, a read of address 0 (timer) and a read of address 1 (count) both return 0.
- R2: A write to address 0 loads the timer with the written value; the value is 32 bits wide by default. While the timer is above 1, it decreases by exactly one per clock, and a read of address 0 returns the remaining clocks.
- R3: A write to address 0 clears the count in the same edge that loads the timer. Event strobes present in the write cycle are not counted.
- R4: While the timer is nonzero and is not in its final clock, each strobe on `sec_a_rd_ok` or `sec_b_rd_ok` adds one to the count.
- R5: Strobes on both ports in the same clock add 2 to the count.
- R6: While the timer is zero, strobes have no effect, and the count and timer stay at 0.
- R7: In the clock where the timer holds 1, the window expires: on the next edge the timer and the count both become 0, and strobes in that clock are discarded.
- R8: A nonzero write to address 0 during an active window restarts the window from the new value and clears the count.
- R9: Writing 0 to address 0 stops an active window. Timer and count read 0 afterwards and stay at 0 while strobes continue.
- R10: The count saturates at its all-ones value (2^CNT_W-1) and never wraps, including when a +2 step would pass the maximum.
- R11: `rd_valid` is high exactly one clock after each `rd_en`. `rd_data` then carries the selected register as it stood at the request edge.
- R12: A read of address 2 or 3 returns 0. A write to any address other than 0 changes neither the timer nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read request |
| rd_addr | input | ADDR_W | Register read word address |
| rd_valid | output | 1 | Read response valid, one clock after rd_en |
| rd_data | output | DATA_W | Read response data |
| sec_a_rd_ok | input | 1 | Single-cycle strobe: successful I/O read on secondary port A |
| sec_b_rd_ok | input | 1 | Single-cycle strobe: successful I/O read on secondary port B |

## Verification
A wrong internal state shows at the ports on the next read response, one clock after the request.
- A timer that slips, sticks or fails to clear gives a remaining-clock value that is off by a growing amount.
- A count that misses an event, double-counts a paired strobe, wraps or survives an expiry or rewrite reads back wrong at once.

Reads are interleaved with every stimulus pattern, so an error is caught within a few clocks of where it arises. A second, narrow-counter instance is driven in parallel and brings out the saturation corner quickly.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam int PWC_ADDR_W = 2;
  localparam logic [PWC_ADDR_W-1:0] PWC_ADR_TIMER = 2'd0;
  localparam logic [PWC_ADDR_W-1:0] PWC_ADR_COUNT = 2'd1;
endpackage

// File: rtl/pwc_window_timer.sv
module pwc_window_timer #(
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic [TMR_W-1:0] tmr_q,
  output logic             active,
  output logic             expire
);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  assign active = (tmr_q != '0);
  assign expire = (tmr_q == ONE) && !load;

  always_ff @(posedge clk) begin
    if (!rst_n)      tmr_q <= '0;
    else if (load)   tmr_q <= load_val;
    else if (active) tmr_q <= tmr_q - ONE;
  end
endmodule

// File: rtl/pwc_event_counter.sv
module pwc_event_counter #(
  parameter int CNT_W = 32,
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic [N_SRC-1:0] ev,
  output logic [CNT_W-1:0] cnt_q
);
  localparam int INC_W = $clog2(N_SRC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [INC_W-1:0] inc;
  logic [CNT_W:0]   sum;

  always_comb begin
    inc = '0;
    for (int i = 0; i < N_SRC; i++) inc = inc + INC_W'(ev[i]);
  end

  assign sum = {1'b0, cnt_q} + (CNT_W + 1)'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (enable) cnt_q <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  end
endmodule

// File: rtl/pwc_read_port.sv
module pwc_read_port
  import pwc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TMR_W  = 32,
  parameter int CNT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic [PWC_ADDR_W-1:0] rd_addr,
  input  logic [TMR_W-1:0]      tmr,
  input  logic [CNT_W-1:0]      cnt,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    case (rd_addr)
      PWC_ADR_TIMER: sel = DATA_W'(tmr);
      PWC_ADR_COUNT: sel = DATA_W'(cnt);
      default:       sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end
endmodule

// File: rtl/perf_window_counter.sv
module perf_window_counter
  import pwc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TMR_W  = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = PWC_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sec_a_rd_ok,
  input  logic              sec_b_rd_ok
);
  localparam int N_SRC = 2;

  logic             tmr_load;
  logic             win_active;
  logic             win_expire;
  logic [TMR_W-1:0] tmr_q;
  logic [CNT_W-1:0] cnt_q;

  assign tmr_load = wr_en && (wr_addr == PWC_ADR_TIMER);

  pwc_window_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (wr_data[TMR_W-1:0]),
    .tmr_q    (tmr_q),
    .active   (win_active),
    .expire   (win_expire)
  );

  pwc_event_counter #(.CNT_W(CNT_W), .N_SRC(N_SRC)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (tmr_load || win_expire),
    .enable (win_active),
    .ev     ({sec_b_rd_ok, sec_a_rd_ok}),
    .cnt_q  (cnt_q)
  );

  pwc_read_port #(.DATA_W(DATA_W), .TMR_W(TMR_W), .CNT_W(CNT_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .tmr      (tmr_q),
    .cnt      (cnt_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int DATA_W = 32,
  parameter int TMR_W  = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [TMR_W-1:0]  tmr_q,
  input logic [CNT_W-1:0]  cnt_q
);
  logic twr;
  assign twr = wr_en && (wr_addr == '0);

  // R3
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    twr |=> (cnt_q == '0) && (tmr_q == $past(wr_data[TMR_W-1:0])));

  // R2
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!twr && tmr_q > TMR_W'(1)) |=> tmr_q == $past(tmr_q) - TMR_W'(1));

  // R7
  expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!twr && tmr_q == TMR_W'(1)) |=> (tmr_q == '0) && (cnt_q == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!twr && tmr_q == '0) |=> (tmr_q == '0) && (cnt_q == '0));

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!twr && tmr_q > TMR_W'(1)) |=> cnt_q >= $past(cnt_q));

  // R11
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R11
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

bind perf_window_counter pwc_checker #(
  .DATA_W(DATA_W), .TMR_W(TMR_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_pwc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .tmr_q    (tmr_q),
  .cnt_q    (cnt_q)
);

// File: tb/test_perf_window_counter.sv
`timescale 1ns/1ps
module test_perf_window_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic        ev_a = 1'b0;
  logic        ev_b = 1'b0;
  logic        rv_m, rv_s;
  logic [31:0] rd_m, rd_s;

  always #2 clk = ~clk;

  perf_window_counter i_perf_window_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rv_m), .rd_data(rd_m),
    .sec_a_rd_ok(ev_a), .sec_b_rd_ok(ev_b));

  // narrow instance: 8-bit timer, 3-bit count, for the saturation corner
  perf_window_counter #(.TMR_W(8), .CNT_W(3)) i_perf_window_counter_sat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rv_s), .rd_data(rd_s),
    .sec_a_rd_ok(ev_a), .sec_b_rd_ok(ev_b));

  typedef struct {
    logic [31:0] exp_m;
    logic [31:0] exp_s;
    string       tag;
  } item_t;

  item_t q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  longint mt = 0, mc = 0, st = 0, sc = 0;

  function automatic void adv(ref longint t, ref longint c, input longint tmax, input longint cmax,
                              input logic w, input logic [1:0] wa, input logic [31:0] wd,
                              input logic a, input logic b);
    if (w && wa == 2'd0) begin
      t = longint'(wd) & tmax;
      c = 0;
    end else if (t == 1) begin
      t = 0;
      c = 0;
    end else if (t != 0) begin
      t = t - 1;
      c = c + longint'(a) + longint'(b);
      if (c > cmax) c = cmax;
    end
  endfunction

  function automatic logic [31:0] pick(input logic [1:0] ra, input longint t, input longint c);
    if (ra == 2'd0) return 32'(t);
    if (ra == 2'd1) return 32'(c);
    return 32'd0;
  endfunction

  // driver: drive one clock of stimulus, push expected read result
  task automatic step(input logic w, input logic [1:0] wa, input logic [31:0] wd,
                      input logic r, input logic [1:0] ra,
                      input logic a, input logic b, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = w; wr_addr = wa; wr_data = wd;
    rd_en = r; rd_addr = ra; ev_a = a; ev_b = b;
    if (r) begin
      it.exp_m = pick(ra, mt, mc);
      it.exp_s = pick(ra, st, sc);
      it.tag = tag;
      q.push_back(it);
    end
    adv(mt, mc, 64'hFFFF_FFFF, 64'hFFFF_FFFF, w, wa, wd, a, b);
    adv(st, sc, 64'hFF, 64'h7, w, wa, wd, a, b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic rd(input logic [1:0] ra, input logic a, input logic b, input string tag);
    step(0, 0, 0, 1, ra, a, b, tag);
  endtask

  task automatic wr(input logic [1:0] wa, input logic [31:0] wd, input logic a, input logic b);
    step(1, wa, wd, 0, 0, a, b, "");
  endtask

  // monitor: pop expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rv_m) begin
        if (q.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R11: unexpected rd_valid, got 1 exp 0");
        end else begin
          item_t it;
          it = q.pop_front();
          n_run++;
          if (rd_m !== it.exp_m) begin
            n_fail++;
            $display("FAIL %s: main rd_data got %0h exp %0h", it.tag, rd_m, it.exp_m);
          end
          n_run++;
          if (rd_s !== it.exp_s || rv_s !== 1'b1) begin
            n_fail++;
            $display("FAIL %s: narrow rd_data got %0h exp %0h", it.tag, rd_s, it.exp_s);
          end
        end
      end else if (q.size() != 0 && q.size() > 1) begin
        n_run++; n_fail++;
        $display("FAIL R11: rd_valid missing, got 0 exp 1");
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, 0, 0, "R1"); rd(1, 0, 0, "R1");
    // R3: load 10, strobe in the write cycle is ignored
    wr(0, 10, 1, 1);
    rd(1, 0, 0, "R3");
    rd(0, 0, 0, "R2");
    // R4 single strobes on each port
    rd(1, 1, 0, "R4"); rd(1, 0, 1, "R4"); rd(1, 0, 0, "R4");
    // R5 both ports together
    rd(1, 1, 1, "R5"); rd(1, 0, 0, "R5");
    rd(0, 0, 0, "R2");
    // R7: remaining timer drains; strobe in the final clock discarded
    rd(0, 0, 0, "R7");
    rd(1, 1, 1, "R7");
    rd(0, 0, 0, "R7");
    rd(1, 0, 0, "R7");
    // R6: strobes with no window
    rd(1, 1, 1, "R6"); rd(1, 1, 0, "R6"); rd(0, 0, 1, "R6");
    // R8 rewrite during active window
    wr(0, 50, 0, 0);
    rd(1, 1, 1, "R8"); rd(1, 1, 1, "R8"); rd(1, 0, 0, "R8");
    wr(0, 30, 1, 0);
    rd(1, 0, 0, "R8"); rd(0, 0, 0, "R8");
    // R12 write to other addresses is ignored; unused reads are zero
    step(1, 2'd1, 32'h0000_0055, 1, 2'd1, 0, 0, "R12");
    step(1, 2'd3, 32'h0000_0003, 1, 2'd0, 0, 0, "R12");
    rd(1, 0, 0, "R12"); rd(0, 0, 0, "R12");
    rd(2, 0, 0, "R12"); rd(3, 0, 0, "R12");
    // R9 write zero stops the window
    wr(0, 0, 1, 1);
    rd(0, 1, 1, "R9"); rd(1, 1, 1, "R9"); rd(1, 0, 0, "R9");
    // R2 full-width load
    wr(0, 32'hFFFF_FFF0, 0, 0);
    rd(0, 0, 0, "R2"); rd(0, 0, 0, "R2");
    // R10 saturation on narrow instance, wide one keeps counting
    wr(0, 100, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 1, 1, "");
    rd(1, 1, 0, "R10"); rd(1, 1, 1, "R10"); rd(1, 0, 0, "R10");
    // R11 back-to-back reads with alternating addresses
    rd(0, 0, 0, "R11"); rd(1, 0, 0, "R11"); rd(0, 0, 0, "R11");
    idle(2);
    // R11 response must not persist after an idle cycle
    @(negedge clk);
    n_run++;
    if (rv_m !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: rd_valid idle got %b exp 0", rv_m);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule